// File: doc/BRIEF.md
# Twelve-Hour BCD Time-of-Day Counter

This block keeps time of day as six binary-coded decimal digits: two for seconds, two for minutes and two for hours. The hours run from 00 to 11. It runs on the system clock and moves forward by one second on each cycle where a one-cycle tick enable is high. The tick is normally produced once per second by a prescaler outside the block.

When the seconds go from 59 back to 00, the minutes step forward. When the minutes go from 59 back to 00, the hours step forward. After 11 the hours return to 00, so 11:59:59 is followed directly by 00:00:00. Every digit register sits in the same clock domain. Each digit is enabled by a combinational carry from the digits below it, and no digit uses another digit as its clock.

Two registered strobes mark the field rollovers. Display decoding, time setting and half-day indication are left to the surrounding logic.

Top module: `bcd_time12`

## Requirements
- R1: The seconds units digit (`sec_lo`) counts 0 to 9 on ticks and then returns to 0. Each time it returns to 0, the seconds tens digit (`sec_hi`) steps forward, counting 0 to 5 and then returning to 0. Seconds therefore cycle modulo 60.
- R2: On a tick where the seconds read 59, the minutes digits (`min_hi`:`min_lo`) step forward by one in BCD. They cycle 00 to 59 and then return to 00.
- R3: On a tick where the minutes and seconds read 59:59, the hours digits (`hr_hi`:`hr_lo`) step forward by one. They only ever show 00 to 11, with `hr_hi` at most 1, and they never show 12.
- R4: A tick taken at 11:59:59 leaves all six digits at 0.
- R5: On a clock edge where `tick` is low, all six digits hold their values and both strobes are low in the following cycle.
- R6: If `rst` is high at a rising edge, all six digits and both strobes are cleared at that edge, whatever the value of `tick`.
- R7: `sec_wrap` is high for exactly the one cycle after a tick that took the seconds from 59 to 00. In that cycle the seconds read 00.
- R8: `min_wrap` is high for exactly the one cycle after a tick that took the minutes and seconds from 59:59 to 00:00. Whenever `min_wrap` is high, `sec_wrap` is also high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-second advance enable |
| sec_lo | output | 4 | Seconds units digit, BCD |
| sec_hi | output | 4 | Seconds tens digit, BCD |
| min_lo | output | 4 | Minutes units digit, BCD |
| min_hi | output | 4 | Minutes tens digit, BCD |
| hr_lo | output | 4 | Hours units digit, BCD |
| hr_hi | output | 4 | Hours tens digit, BCD |
| sec_wrap | output | 1 | One-cycle strobe after seconds roll 59 to 00 |
| min_wrap | output | 1 | One-cycle strobe after minutes roll 59 to 00 |

## Verification
The first input pattern alternates `tick` high and low. This separates digits that truly hold on an idle cycle from digits that advance on every clock. The second pattern holds `tick` high on every cycle for more than 43,200 ticks, covering every state of the half day. The bench compares the digits against a seconds counter kept modulo 43200, so a fault in any single carry, any limit of 5, 9 or 11, or the 11:59:59 rollover shows up as a mismatch at the exact second where it occurs. The final pattern raises reset together with a tick partway through the count, to show that reset wins over the tick.

// File: rtl/bcd_time12.sv
module bcd_time12 (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  output logic [3:0] sec_lo,
  output logic [3:0] sec_hi,
  output logic [3:0] min_lo,
  output logic [3:0] min_hi,
  output logic [3:0] hr_lo,
  output logic [3:0] hr_hi,
  output logic       sec_wrap,
  output logic       min_wrap
);

  logic s_lo_end, s_end, m_lo_end, m_end, h_end;

  assign s_lo_end = (sec_lo == 4'd9);
  assign s_end    = s_lo_end && (sec_hi == 4'd5);
  assign m_lo_end = (min_lo == 4'd9);
  assign m_end    = m_lo_end && (min_hi == 4'd5);
  assign h_end    = (hr_hi == 4'd1) && (hr_lo == 4'd1);

  always_ff @(posedge clk) begin
    if (rst) begin
      sec_lo   <= '0;
      sec_hi   <= '0;
      min_lo   <= '0;
      min_hi   <= '0;
      hr_lo    <= '0;
      hr_hi    <= '0;
      sec_wrap <= 1'b0;
      min_wrap <= 1'b0;
    end else begin
      sec_wrap <= tick && s_end;
      min_wrap <= tick && s_end && m_end;
      if (tick) begin
        sec_lo <= s_lo_end ? 4'd0 : sec_lo + 4'd1;
        if (s_lo_end)
          sec_hi <= s_end ? 4'd0 : sec_hi + 4'd1;
        if (s_end) begin
          min_lo <= m_lo_end ? 4'd0 : min_lo + 4'd1;
          if (m_lo_end)
            min_hi <= m_end ? 4'd0 : min_hi + 4'd1;
          if (m_end) begin
            if (h_end) begin
              hr_lo <= 4'd0;
              hr_hi <= 4'd0;
            end else if (hr_lo == 4'd9) begin
              hr_lo <= 4'd0;
              hr_hi <= hr_hi + 4'd1;
            end else begin
              hr_lo <= hr_lo + 4'd1;
            end
          end
        end
      end
    end
  end

endmodule

module bcd_time12_chk (
  input logic       clk,
  input logic       rst,
  input logic       tick,
  input logic [3:0] sec_lo,
  input logic [3:0] sec_hi,
  input logic [3:0] min_lo,
  input logic [3:0] min_hi,
  input logic [3:0] hr_lo,
  input logic [3:0] hr_hi,
  input logic       sec_wrap,
  input logic       min_wrap
);

  logic [23:0] digits;
  assign digits = {hr_hi, hr_lo, min_hi, min_lo, sec_hi, sec_lo};

  assert_sec_range_R1: assert property (@(posedge clk) disable iff (rst)
    (sec_lo <= 4'd9) && (sec_hi <= 4'd5));

  assert_min_range_R2: assert property (@(posedge clk) disable iff (rst)
    (min_lo <= 4'd9) && (min_hi <= 4'd5));

  assert_hour_range_R3: assert property (@(posedge clk) disable iff (rst)
    (hr_hi <= 4'd1) && (hr_hi == 4'd1 ? hr_lo <= 4'd1 : hr_lo <= 4'd9));

  assert_rollover_R4: assert property (@(posedge clk) disable iff (rst)
    (tick && digits == 24'h115959) |=> (digits == 24'h0));

  assert_hold_R5: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ($stable(digits) && !sec_wrap && !min_wrap));

  assert_reset_R6: assert property (@(posedge clk)
    rst |=> (digits == 24'h0 && !sec_wrap && !min_wrap));

  assert_sec_wrap_R7: assert property (@(posedge clk) disable iff (rst)
    sec_wrap |-> (sec_lo == 4'd0 && sec_hi == 4'd0));

  assert_sec_wrap_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    sec_wrap |=> !sec_wrap);

  assert_min_wrap_R8: assert property (@(posedge clk) disable iff (rst)
    min_wrap |-> (sec_wrap && min_lo == 4'd0 && min_hi == 4'd0));

endmodule

bind bcd_time12 bcd_time12_chk u_chk (
  .clk(clk), .rst(rst), .tick(tick),
  .sec_lo(sec_lo), .sec_hi(sec_hi), .min_lo(min_lo), .min_hi(min_hi),
  .hr_lo(hr_lo), .hr_hi(hr_hi), .sec_wrap(sec_wrap), .min_wrap(min_wrap)
);

// File: tb/bcd_time12_tb.sv
`timescale 1ns/1ps
module bcd_time12_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic [3:0] sec_lo, sec_hi, min_lo, min_hi, hr_lo, hr_hi;
  logic sec_wrap, min_wrap;

  int n_cmp = 0;
  int n_bad = 0;
  int ref_t = 0;
  bit done = 0;

  always #10 clk = ~clk;

  bcd_time12 u_dut (
    .clk(clk), .rst(rst), .tick(tick),
    .sec_lo(sec_lo), .sec_hi(sec_hi), .min_lo(min_lo), .min_hi(min_hi),
    .hr_lo(hr_lo), .hr_hi(hr_hi), .sec_wrap(sec_wrap), .min_wrap(min_wrap)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s at t=%0d: actual %0d expected %0d", tag, ref_t, act, exp);
    end
  endtask

  task automatic compare(input string ts, input string tm, input string th,
                         input int esw, input int emw);
    int h, m, s;
    h = ref_t / 3600;
    m = (ref_t / 60) % 60;
    s = ref_t % 60;
    chk(ts, sec_lo, s % 10);
    chk(ts, sec_hi, s / 10);
    chk(tm, min_lo, m % 10);
    chk(tm, min_hi, m / 10);
    chk(th, hr_lo, h % 10);
    chk(th, hr_hi, h / 10);
    chk("R7", sec_wrap, esw);
    chk("R8", min_wrap, emw);
  endtask

  task automatic cycle(input logic t);
    int esw, emw;
    tick = t;
    @(posedge clk);
    if (t) ref_t = (ref_t + 1) % 43200;
    esw = (t && ref_t % 60 == 0) ? 1 : 0;
    emw = (t && ref_t % 3600 == 0) ? 1 : 0;
    @(negedge clk);
    if (!t) compare("R5", "R5", "R5", 0, 0);
    else if (ref_t == 0) compare("R4", "R4", "R4", esw, emw);
    else compare("R1", "R2", "R3", esw, emw);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R6: reset state
    repeat (2) @(posedge clk);
    @(negedge clk);
    compare("R6", "R6", "R6", 0, 0);
    rst = 1'b0;

    // alternating tick: hold on idle cycles (R5), steady advance (R1)
    for (int i = 0; i < 300; i++) cycle(i % 2 == 0);

    // back-to-back ticks across a full half-day rollover (R1..R4, R7, R8)
    for (int i = 0; i < 43200 + 200; i++) cycle(1'b1);

    // R6: reset wins over a simultaneous tick
    tick = 1'b1;
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    ref_t = 0;
    compare("R6", "R6", "R6", 0, 0);
    rst = 1'b0;
    tick = 1'b0;

    for (int i = 0; i < 70; i++) cycle(1'b1);
    finish_run();
  end

endmodule